// File: doc/BRIEF.md
# Dual-Ratio Aligned Clock Divider

This block turns one input clock into two groups of divided clocks. Group A runs at one half or one quarter of the input rate. Group B runs at one quarter or one sixth. Each group has its own select bit. Every output has a 50% duty cycle. Each output comes with a separately registered complement, so the pair behaves like a differential clock.

All outputs are decoded from one shared phase counter. Its span is the least common multiple of the full output periods, which is 12 input cycles with the default ratios. Because of this, edges that the groups have in common fall on the same input edge. The active-low run input is captured on the falling input edge. Its effect can therefore only begin or end on a whole rising-edge boundary. The master reset is asynchronous and parks every divider at a common phase, so several instances released together stay in step.

The controller is a small state machine with three states:
- ST_PARK: entered on reset. All true outputs are low.
- ST_RUN: the last rising edge was enabled.
- ST_HOLD: the last rising edge was disabled after a launch.

It has these transitions:
- launch (ST_PARK to ST_RUN): the first enabled edge. The phase loads zero and the selects are captured.
- advance (ST_RUN or ST_HOLD to ST_RUN): an enabled edge. The phase steps and wraps to zero after the last phase.
- pause (ST_RUN or ST_HOLD to ST_HOLD): a disabled edge. The phase and outputs are frozen.
- reset (any state to ST_PARK): the master reset is asserted.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: Group A toggles with a half-period of 1 input cycle when sel_a_i is 0 (divide by 2) and 2 input cycles when sel_a_i is 1 (divide by 4).
- R2: Group B has a half-period of 2 input cycles when sel_b_i is 0 (divide by 4) and 3 input cycles when sel_b_i is 1 (divide by 6, high 3 cycles and low 3 cycles).
- R3: Every complement output is the exact inverse of its true output at all times, and all copies within a group are equal.
- R4: When the sampled run input is inactive (run_n_i high), a rising edge leaves every output unchanged.
- R5: run_n_i is captured on the falling input edge and acts on the following rising edge. Outputs never change between a falling edge and the next rising edge.
- R6: While rst_i is high (asynchronous), all true outputs are 0, all complements are 1, and the block is parked.
- R7: The first enabled rising edge after reset (launch) drives every true output high on that same edge. This is phase 0.
- R8: Whenever the shared phase returns to 0 (every 12 enabled edges after launch), all true outputs rise on that same edge.
- R9: A select change is applied only at launch or at phase 0. A ratio therefore never changes in mid-period and never produces a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Asynchronous master reset, active high |
| run_n_i | input | 1 | Run enable, active low, captured on the falling clock edge |
| sel_a_i | input | 1 | Group A ratio: 0 = divide by 2, 1 = divide by 4 |
| sel_b_i | input | 1 | Group B ratio: 0 = divide by 4, 1 = divide by 6 |
| pa_o | output | NUM_A | Group A divided clocks, true copies |
| pa_n_o | output | NUM_A | Group A complements |
| pb_o | output | NUM_B | Group B divided clocks, true copies |
| pb_n_o | output | NUM_B | Group B complements |

## Verification
The assertions check four properties on every clock:
- the complement and copy relations;
- the freeze of all outputs after a disabled edge;
- the low outputs while parked;
- the all-high launch edge.

The periods, the duty cycle of each ratio, the alignment at phase zero, and the deferral of select changes to the common boundary depend on the history of many edges. Only the bench's cycle-accurate model of the requirements shows these, under directed and random run, select and reset patterns. The absence of mid-cycle output changes is observed by the bench sampling at both clock phases.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ctr_state_e;

    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int unsigned lcm_u(input int unsigned a, input int unsigned b);
        return (a / gcd_u(a, b)) * b;
    endfunction

    // High for the first 'half' phases of each 2*half window
    function automatic logic phase_level(input int unsigned phase, input int unsigned half);
        return (phase % (2 * half)) < half;
    endfunction

endpackage

// File: rtl/dcd_run_sync.sv
module dcd_run_sync (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_n_i,
    output logic run_q_o
);

    // Captured while the clock is high-to-low, so the gate only moves in the low phase
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            run_q_o <= 1'b0;
        end else begin
            run_q_o <= ~run_n_i;
        end
    end

endmodule

// File: rtl/dcd_phase_ctr.sv
module dcd_phase_ctr #(
    parameter int unsigned SPAN = 12,
    parameter int unsigned PW   = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    run_i,
    input  logic                    sel_a_i,
    input  logic                    sel_b_i,
    output dcd_pkg::ctr_state_e     state_o,
    output logic                    adv_o,
    output logic [PW-1:0]           nxt_phase_o,
    output logic                    nxt_sel_a_o,
    output logic                    nxt_sel_b_o
);

    localparam logic [PW-1:0] LAST_PHASE = PW'(SPAN - 1);

    dcd_pkg::ctr_state_e state_q, state_d;
    logic [PW-1:0]       phase_q, phase_d;
    logic                sel_a_q, sel_a_d;
    logic                sel_b_q, sel_b_d;

    // State register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= dcd_pkg::ST_PARK;
            phase_q <= '0;
            sel_a_q <= 1'b0;
            sel_b_q <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            sel_a_q <= sel_a_d;
            sel_b_q <= sel_b_d;
        end
    end

    // Next state, phase and active ratios
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        sel_a_d = sel_a_q;
        sel_b_d = sel_b_q;
        unique case (state_q)
            dcd_pkg::ST_PARK: begin
                if (run_i) begin
                    state_d = dcd_pkg::ST_RUN;
                    phase_d = '0;
                    sel_a_d = sel_a_i;
                    sel_b_d = sel_b_i;
                end
            end
            dcd_pkg::ST_RUN, dcd_pkg::ST_HOLD: begin
                if (run_i) begin
                    state_d = dcd_pkg::ST_RUN;
                    if (phase_q == LAST_PHASE) begin
                        phase_d = '0;
                        sel_a_d = sel_a_i;
                        sel_b_d = sel_b_i;
                    end else begin
                        phase_d = phase_q + PW'(1);
                    end
                end else begin
                    state_d = dcd_pkg::ST_HOLD;
                end
            end
            default: begin
                state_d = dcd_pkg::ST_PARK;
            end
        endcase
    end

    // Outputs toward the output banks
    always_comb begin
        state_o     = state_q;
        adv_o       = run_i;
        nxt_phase_o = phase_d;
        nxt_sel_a_o = sel_a_d;
        nxt_sel_b_o = sel_b_d;
    end

endmodule

// File: rtl/dcd_out_bank.sv
module dcd_out_bank #(
    parameter int unsigned COPIES  = 2,
    parameter int unsigned HALF_LO = 1,
    parameter int unsigned HALF_HI = 2,
    parameter int unsigned PW      = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    input  logic [PW-1:0]     phase_i,
    input  logic              sel_i,
    output logic [COPIES-1:0] q_o,
    output logic [COPIES-1:0] qn_o
);

    logic level;

    always_comb begin
        level = dcd_pkg::phase_level(32'(phase_i), sel_i ? HALF_HI : HALF_LO);
    end

    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        logic t_q;
        logic c_q;

        // True and complement each get their own flop
        always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
                t_q <= 1'b0;
                c_q <= 1'b1;
            end else if (adv_i) begin
                t_q <= level;
                c_q <= ~level;
            end
        end

        assign q_o[g]  = t_q;
        assign qn_o[g] = c_q;
    end

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv #(
    parameter int unsigned NUM_A     = 2,
    parameter int unsigned NUM_B     = 2,
    parameter int unsigned A_HALF_LO = 1,
    parameter int unsigned A_HALF_HI = 2,
    parameter int unsigned B_HALF_LO = 2,
    parameter int unsigned B_HALF_HI = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_n_i,
    input  logic             sel_a_i,
    input  logic             sel_b_i,
    output logic [NUM_A-1:0] pa_o,
    output logic [NUM_A-1:0] pa_n_o,
    output logic [NUM_B-1:0] pb_o,
    output logic [NUM_B-1:0] pb_n_o
);

    localparam int unsigned SPAN_A = dcd_pkg::lcm_u(2 * A_HALF_LO, 2 * A_HALF_HI);
    localparam int unsigned SPAN_B = dcd_pkg::lcm_u(2 * B_HALF_LO, 2 * B_HALF_HI);
    localparam int unsigned SPAN   = dcd_pkg::lcm_u(SPAN_A, SPAN_B);
    localparam int unsigned PW     = (SPAN > 2) ? $clog2(SPAN) : 1;

    logic                run_q;
    logic                adv;
    logic [PW-1:0]       nxt_phase;
    logic                nxt_sel_a;
    logic                nxt_sel_b;
    dcd_pkg::ctr_state_e ctr_state;

    dcd_run_sync u_run (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_n_i (run_n_i),
        .run_q_o (run_q)
    );

    dcd_phase_ctr #(
        .SPAN (SPAN),
        .PW   (PW)
    ) u_ctr (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .run_i       (run_q),
        .sel_a_i     (sel_a_i),
        .sel_b_i     (sel_b_i),
        .state_o     (ctr_state),
        .adv_o       (adv),
        .nxt_phase_o (nxt_phase),
        .nxt_sel_a_o (nxt_sel_a),
        .nxt_sel_b_o (nxt_sel_b)
    );

    dcd_out_bank #(
        .COPIES  (NUM_A),
        .HALF_LO (A_HALF_LO),
        .HALF_HI (A_HALF_HI),
        .PW      (PW)
    ) u_bank_a (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (adv),
        .phase_i (nxt_phase),
        .sel_i   (nxt_sel_a),
        .q_o     (pa_o),
        .qn_o    (pa_n_o)
    );

    dcd_out_bank #(
        .COPIES  (NUM_B),
        .HALF_LO (B_HALF_LO),
        .HALF_HI (B_HALF_HI),
        .PW      (PW)
    ) u_bank_b (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (adv),
        .phase_i (nxt_phase),
        .sel_i   (nxt_sel_b),
        .q_o     (pb_o),
        .qn_o    (pb_n_o)
    );

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int unsigned NA = 2,
    parameter int unsigned NB = 2
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                run_q_i,
    input dcd_pkg::ctr_state_e state_i,
    input logic [NA-1:0]       pa_i,
    input logic [NA-1:0]       pan_i,
    input logic [NB-1:0]       pb_i,
    input logic [NB-1:0]       pbn_i
);

    a_r3_complement: assert property (@(posedge clk_i) disable iff (rst_i)
        (pan_i == ~pa_i) && (pbn_i == ~pb_i));

    a_r3_copies: assert property (@(posedge clk_i) disable iff (rst_i)
        (pa_i == {NA{pa_i[0]}}) && (pb_i == {NB{pb_i[0]}}));

    a_r4_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_q_i |=> ($stable(pa_i) && $stable(pb_i)));

    a_r6_parked_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == dcd_pkg::ST_PARK) |-> ((pa_i == '0) && (pb_i == '0)));

    a_r7_launch: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_i == dcd_pkg::ST_PARK) && run_q_i) |=> ((&pa_i) && (&pb_i)));

endmodule

bind dual_ratio_clkdiv dcd_checker #(
    .NA (NUM_A),
    .NB (NUM_B)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_q_i (run_q),
    .state_i (ctr_state),
    .pa_i    (pa_o),
    .pan_i   (pa_n_o),
    .pb_i    (pb_o),
    .pbn_i   (pb_n_o)
);

// File: tb/dual_ratio_clkdiv_test.sv
module dual_ratio_clkdiv_test;

    localparam int NA   = 2;
    localparam int NB   = 2;
    localparam int SPAN = 12;

    logic          clk = 1'b0;
    logic          rst_i;
    logic          run_n_i;
    logic          sel_a_i;
    logic          sel_b_i;
    logic [NA-1:0] pa_o, pa_n_o;
    logic [NB-1:0] pb_o, pb_n_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model state
    bit  m_run  = 1'b0;
    bit  m_park = 1'b1;
    int  m_ph   = 0;
    bit  m_a    = 1'b0;
    bit  m_b    = 1'b0;

    always #5 clk = ~clk;

    dual_ratio_clkdiv uut (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .run_n_i (run_n_i),
        .sel_a_i (sel_a_i),
        .sel_b_i (sel_b_i),
        .pa_o    (pa_o),
        .pa_n_o  (pa_n_o),
        .pb_o    (pb_o),
        .pb_n_o  (pb_n_o)
    );

    function automatic bit lvl(input int ph, input int half);
        return (ph % (2 * half)) < half;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] outs();
        return 8'({pa_o, pa_n_o, pb_o, pb_n_o});
    endfunction

    // One input cycle, entered and left at rising edge + 2
    task automatic cyc(input bit r, input bit rn, input bit a, input bit b);
        logic [7:0] snap;
        logic [7:0] exp;
        bit         ea, eb, launch, pend;
        string      ta, tb;
        rst_i = r; run_n_i = rn; sel_a_i = a; sel_b_i = b;
        #1;
        snap = outs();
        @(negedge clk); #1;
        check(outs() == snap, "R5 no change before rising edge", outs(), snap);
        m_run = r ? 1'b0 : !rn;
        @(posedge clk); #2;
        launch = 1'b0;
        if (r) begin
            m_park = 1'b1; m_ph = 0;
        end else if (m_run) begin
            if (m_park) begin
                m_park = 1'b0; m_ph = 0; m_a = a; m_b = b; launch = 1'b1;
            end else begin
                m_ph = (m_ph + 1) % SPAN;
                if (m_ph == 0) begin m_a = a; m_b = b; end
            end
        end
        ea = m_park ? 1'b0 : lvl(m_ph, m_a ? 2 : 1);
        eb = m_park ? 1'b0 : lvl(m_ph, m_b ? 3 : 2);
        pend = (m_a != a) || (m_b != b);
        if (r)                     begin ta = "R6 reset";   tb = "R6 reset";  end
        else if (launch)           begin ta = "R7 launch";  tb = "R7 launch"; end
        else if (!m_run && !m_park) begin ta = "R4 hold";   tb = "R4 hold";   end
        else if (pend)             begin ta = "R9 select deferred"; tb = ta;  end
        else                       begin ta = "R1 group A"; tb = "R2 group B"; end
        exp = 8'({{NA{ea}}, {NA{~ea}}, {NB{eb}}, {NB{~eb}}});
        check({pa_o, pa_n_o} == exp[7:4], ta, outs(), exp);
        check({pb_o, pb_n_o} == exp[3:0], tb, outs(), exp);
        check((pa_n_o == ~pa_o) && (pb_n_o == ~pb_o), "R3 complement", outs(), exp);
        if (!m_park && m_run && m_ph == 0)
            check((&pa_o) && (&pb_o), "R8 phase zero alignment", outs(), 8'hFF);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit rn, a, b, r;
        void'($urandom(32'd1957));
        rst_i = 1'b1; run_n_i = 1'b1; sel_a_i = 1'b0; sel_b_i = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check({pa_o, pb_o} == '0 && {pa_n_o, pb_n_o} == '1, "R6 reset state", outs(), 8'h33);

        // Directed: divide by 2 and 4
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        // Select change mid-period, deferred to phase zero
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1);
        // Hold for a while, then resume
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1);
        // Rapid run toggling
        for (int i = 0; i < 20; i++) cyc(1'b0, i[0], 1'b0, 1'b1);
        // Reset in mid-run, then launch with divide by 4 and 6
        cyc(1'b1, 1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 26; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1);
        // Launch delayed while held
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 14; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);

        // Constrained random
        rn = 1'b0; a = 1'b0; b = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(7) == 0)  rn = !rn;
            if ($urandom_range(15) == 0) a = !a;
            if ($urandom_range(15) == 0) b = !b;
            r = ($urandom_range(199) == 0);
            cyc(r, rn, a, b);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule